// File: doc/BRIEF.md
# USB IN Endpoint Interrupt Status Logic

This block raises and holds the interrupt events of the IN direction of a USB control endpoint. The serial engine reports each transmitted IN packet with a strobe and the packet's byte count. The block compares that count with the configured maximum packet size to flag packet completion and transfer completion. It watches the IN FIFO fill level against a programmable threshold. It also follows the endpoint's halt flag together with the cause that moved it.

Every event sets a sticky bit in a five-bit status register. Software clears a bit by writing 1 to its position. A mask register with the same layout selects which status bits drive the single interrupt output. Transfer-end detection keeps a one-bit record of whether the previous packet was full-size. With that record, a zero-length packet closes a transfer only when it follows full-size packets.

Top module: `usb_in_irq_ctrl`

## Requirements
- R1: Status and mask share one layout: bit 4 halt, bit 3 unhalt, bit 2 end-of-packet, bit 1 end-of-transfer, bit 0 FIFO level. After reset both registers are zero and `irq` is 0.
- R2: Every cycle with `tx_done` high sets status bit 2, visible one clock later.
- R3: A transmitted packet with a nonzero `tx_len` below `max_pkt` sets status bit 1.
- R4: A zero-length packet sets status bit 1 only when the previous packet was full-size (`tx_len` equal to `max_pkt`). A zero-length packet after a short packet, after another zero-length packet, or after a bus reset does not set it.
- R5: Status bit 4 is set when `halt_st` goes from 0 to 1 while `stall_cause` is high. A rise without `stall_cause` sets nothing.
- R6: Status bit 3 is set when `halt_st` goes from 1 to 0 while `setup_rx` or `bus_rst` is high. A fall without either sets nothing.
- R7: Status bit 0 is set once when `fifo_lvl` moves from at-or-above `fifo_thr` to below it. It is not set again while the level stays below.
- R8: Status bits are sticky. A write with `wr_sel`=0 clears each bit whose `wr_data` bit is 1 and leaves the others unchanged.
- R9: When a set event and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R10: A write with `wr_sel`=1 loads `wr_data` into the mask. `irq` is high exactly when some status bit and its mask bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_done | input | 1 | IN packet sent successfully, one-cycle strobe |
| tx_len | input | CNT_W | Byte count of the sent packet |
| max_pkt | input | CNT_W | Configured maximum packet size |
| fifo_lvl | input | LVL_W | Current IN FIFO fill level |
| fifo_thr | input | LVL_W | FIFO threshold |
| halt_st | input | 1 | Endpoint halt flag |
| stall_cause | input | 1 | Halt flag set because a STALL was returned |
| setup_rx | input | 1 | SETUP packet received (halt clear cause) |
| bus_rst | input | 1 | USB bus reset seen |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = status clear write, 1 = mask write |
| wr_data | input | 5 | Write data |
| stat_q | output | 5 | Status register |
| mask_q | output | 5 | Mask register |
| irq | output | 1 | Interrupt request |

## Verification
Every event is decoded combinationally from the inputs and lands in the status flop at the next rising edge. A status bit is therefore due one clock after its stimulus. A mask write likewise shows in `mask_q` one clock later, and `irq` follows in the same cycle because it is a pure function of the two registers. The bench drives inputs just after a falling edge and samples at the following falling edge, which is exactly one rising edge later. After each clearing write it checks again at the next falling edge. The zero-length-packet history is checked through sequences of packets, each followed by a clear, so that every check looks at a single packet's effect.

// File: rtl/usb_in_irq_pkg.sv
package usb_in_irq_pkg;
   localparam int IRQ_NB   = 5;
   localparam int B_HALT   = 4;
   localparam int B_UNHALT = 3;
   localparam int B_EOP    = 2;
   localparam int B_EOT    = 1;
   localparam int B_LVL    = 0;
   typedef logic [IRQ_NB-1:0] irq_vec_t;
endpackage

// File: rtl/usb_in_pkt_evt.sv
module usb_in_pkt_evt #(
   parameter int CNT_W   = 11,
   parameter bit FULL_GE = 1'b0   // 1: a count above max also counts as full
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tx_done,
   input  logic [CNT_W-1:0] tx_len,
   input  logic [CNT_W-1:0] max_pkt,
   input  logic             bus_rst,
   output logic             eop_evt,
   output logic             eot_evt
);
   logic is_zero, is_full, is_short;
   logic last_full_q;

   assign is_zero = (tx_len == '0);

   if (FULL_GE) begin : g_full_ge
      assign is_full = (tx_len >= max_pkt) && !is_zero;
   end else begin : g_full_eq
      assign is_full = (tx_len == max_pkt) && !is_zero;
   end

   assign is_short = !is_zero && !is_full;

   assign eop_evt = tx_done;
   assign eot_evt = tx_done && (is_short || (is_zero && last_full_q));

   // history of whether the last packet sent was full-size
   always_ff @(posedge clk) begin
      if (!rst_n || bus_rst)  last_full_q <= 1'b0;
      else if (tx_done)       last_full_q <= is_full;
   end
endmodule

// File: rtl/usb_in_lvl_evt.sv
module usb_in_lvl_evt #(
   parameter int LVL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LVL_W-1:0] fifo_lvl,
   input  logic [LVL_W-1:0] fifo_thr,
   output logic             lvl_evt
);
   logic above_now, above_q;

   assign above_now = (fifo_lvl >= fifo_thr);
   assign lvl_evt   = above_q && !above_now;

   always_ff @(posedge clk) begin
      if (!rst_n) above_q <= 1'b0;
      else        above_q <= above_now;
   end
endmodule

// File: rtl/usb_in_halt_evt.sv
module usb_in_halt_evt (
   input  logic clk,
   input  logic rst_n,
   input  logic halt_st,
   input  logic stall_cause,
   input  logic setup_rx,
   input  logic bus_rst,
   output logic halt_evt,
   output logic unhalt_evt
);
   logic halt_prev_q;

   assign halt_evt   = halt_st && !halt_prev_q && stall_cause;
   assign unhalt_evt = !halt_st && halt_prev_q && (setup_rx || bus_rst);

   always_ff @(posedge clk) begin
      if (!rst_n) halt_prev_q <= 1'b0;
      else        halt_prev_q <= halt_st;
   end
endmodule

// File: rtl/usb_in_irq_regs.sv
module usb_in_irq_regs #(
   parameter int NB = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NB-1:0] set_vec,
   input  logic          wr_en,
   input  logic          wr_sel,
   input  logic [NB-1:0] wr_data,
   output logic [NB-1:0] stat_q,
   output logic [NB-1:0] mask_q,
   output logic          irq
);
   logic [NB-1:0] clr_vec;

   assign clr_vec = (wr_en && !wr_sel) ? wr_data : '0;

   for (genvar i = 0; i < NB; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)          stat_q[i] <= 1'b0;
         else if (set_vec[i]) stat_q[i] <= 1'b1;   // set beats clear
         else if (clr_vec[i]) stat_q[i] <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                mask_q <= '0;
      else if (wr_en && wr_sel)  mask_q <= wr_data;
   end

   assign irq = |(stat_q & mask_q);
endmodule

// File: rtl/usb_in_irq_ctrl.sv
module usb_in_irq_ctrl
   import usb_in_irq_pkg::*;
#(
   parameter int CNT_W   = 11,
   parameter int LVL_W   = 8,
   parameter bit FULL_GE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tx_done,
   input  logic [CNT_W-1:0] tx_len,
   input  logic [CNT_W-1:0] max_pkt,
   input  logic [LVL_W-1:0] fifo_lvl,
   input  logic [LVL_W-1:0] fifo_thr,
   input  logic             halt_st,
   input  logic             stall_cause,
   input  logic             setup_rx,
   input  logic             bus_rst,
   input  logic             wr_en,
   input  logic             wr_sel,
   input  logic [4:0]       wr_data,
   output logic [4:0]       stat_q,
   output logic [4:0]       mask_q,
   output logic             irq
);
   if (CNT_W < 4 || CNT_W > 16) begin : g_bad_cnt
      $error("usb_in_irq_ctrl: CNT_W out of range");
   end
   if (LVL_W < 2 || LVL_W > 16) begin : g_bad_lvl
      $error("usb_in_irq_ctrl: LVL_W out of range");
   end

   logic     eop_evt, eot_evt, lvl_evt, halt_evt, unhalt_evt;
   irq_vec_t set_vec;

   usb_in_pkt_evt #(.CNT_W(CNT_W), .FULL_GE(FULL_GE)) u_pkt (
      .clk(clk), .rst_n(rst_n), .tx_done(tx_done), .tx_len(tx_len),
      .max_pkt(max_pkt), .bus_rst(bus_rst),
      .eop_evt(eop_evt), .eot_evt(eot_evt)
   );

   usb_in_lvl_evt #(.LVL_W(LVL_W)) u_lvl (
      .clk(clk), .rst_n(rst_n), .fifo_lvl(fifo_lvl), .fifo_thr(fifo_thr),
      .lvl_evt(lvl_evt)
   );

   usb_in_halt_evt u_halt (
      .clk(clk), .rst_n(rst_n), .halt_st(halt_st), .stall_cause(stall_cause),
      .setup_rx(setup_rx), .bus_rst(bus_rst),
      .halt_evt(halt_evt), .unhalt_evt(unhalt_evt)
   );

   always_comb begin
      set_vec           = '0;
      set_vec[B_HALT]   = halt_evt;
      set_vec[B_UNHALT] = unhalt_evt;
      set_vec[B_EOP]    = eop_evt;
      set_vec[B_EOT]    = eot_evt;
      set_vec[B_LVL]    = lvl_evt;
   end

   usb_in_irq_regs #(.NB(IRQ_NB)) u_regs (
      .clk(clk), .rst_n(rst_n), .set_vec(set_vec),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .stat_q(stat_q), .mask_q(mask_q), .irq(irq)
   );
endmodule

// File: rtl/usb_in_irq_chk.sv
module usb_in_irq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       tx_done,
   input logic       halt_st,
   input logic       stall_cause,
   input logic       wr_en,
   input logic       wr_sel,
   input logic [4:0] wr_data,
   input logic [4:0] stat_q,
   input logic [4:0] mask_q,
   input logic       irq
);
   // R2: a sent packet always shows in the end-of-packet bit
   a_r2_eop_set: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done |=> stat_q[2]);

   // R5: stall-caused halt sets the halt bit
   a_r5_halt_set: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(halt_st) && stall_cause) |=> stat_q[4]);

   // R8: a set bit stays set unless a clearing write targets it
   for (genvar i = 0; i < 5; i++) begin : g_sticky
      a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         (stat_q[i] && !(wr_en && !wr_sel && wr_data[i])) |=> stat_q[i]);
   end

   // R10: mask write lands one cycle later
   a_r10_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel) |=> (mask_q == $past(wr_data)));

   // R10: no interrupt when nothing is enabled
   a_r10_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == 5'b0) |-> !irq);

   // R1: registers come out of reset cleared
   a_r1_reset_zero: assert property (@(posedge clk)
      $past(!rst_n) |-> (stat_q == 5'b0 && mask_q == 5'b0));
endmodule

bind usb_in_irq_ctrl usb_in_irq_chk u_chk (
   .clk(clk), .rst_n(rst_n), .tx_done(tx_done), .halt_st(halt_st),
   .stall_cause(stall_cause), .wr_en(wr_en), .wr_sel(wr_sel),
   .wr_data(wr_data), .stat_q(stat_q), .mask_q(mask_q), .irq(irq)
);

// File: tb/sim_usb_in_irq_ctrl.sv
module sim_usb_in_irq_ctrl;
   localparam time CLK_PERIOD = 10ns;
   localparam int  CNT_W = 11;
   localparam int  LVL_W = 8;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             tx_done;
   logic [CNT_W-1:0] tx_len;
   logic [CNT_W-1:0] max_pkt;
   logic [LVL_W-1:0] fifo_lvl;
   logic [LVL_W-1:0] fifo_thr;
   logic             halt_st, stall_cause, setup_rx, bus_rst;
   logic             wr_en, wr_sel;
   logic [4:0]       wr_data;
   logic [4:0]       stat_q, mask_q;
   logic             irq;

   int n_chk = 0;
   int n_err = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   usb_in_irq_ctrl #(.CNT_W(CNT_W), .LVL_W(LVL_W)) u0 (
      .clk(clk), .rst_n(rst_n), .tx_done(tx_done), .tx_len(tx_len),
      .max_pkt(max_pkt), .fifo_lvl(fifo_lvl), .fifo_thr(fifo_thr),
      .halt_st(halt_st), .stall_cause(stall_cause), .setup_rx(setup_rx),
      .bus_rst(bus_rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .stat_q(stat_q), .mask_q(mask_q), .irq(irq)
   );

   // vector: {tx, len[10:0], exp_eop, exp_eot}; max_pkt is 64
   localparam int NV = 14;
   localparam logic [13:0] VEC [NV] = '{
      {1'b1, 11'd10, 1'b1, 1'b1},  // short
      {1'b1, 11'd64, 1'b1, 1'b0},  // full
      {1'b1, 11'd0,  1'b1, 1'b1},  // ZLP after full
      {1'b1, 11'd0,  1'b1, 1'b0},  // second ZLP
      {1'b1, 11'd64, 1'b1, 1'b0},
      {1'b1, 11'd64, 1'b1, 1'b0},
      {1'b1, 11'd0,  1'b1, 1'b1},  // ZLP after run of full
      {1'b0, 11'd0,  1'b0, 1'b0},  // idle
      {1'b1, 11'd5,  1'b1, 1'b1},
      {1'b1, 11'd0,  1'b1, 1'b0},  // ZLP after short
      {1'b1, 11'd64, 1'b1, 1'b0},
      {1'b1, 11'd63, 1'b1, 1'b1},  // one below max
      {1'b1, 11'd0,  1'b1, 1'b0},
      {1'b1, 11'd1,  1'b1, 1'b1}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle();
      tx_done = 1'b0; wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
      stall_cause = 1'b0; setup_rx = 1'b0; bus_rst = 1'b0;
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic clr_stat(input logic [4:0] d);
      idle(); wr_en = 1'b1; wr_sel = 1'b0; wr_data = d; tick(); idle();
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=done");
      summary();
   end

   initial begin
      idle();
      rst_n = 1'b0; tx_len = '0; max_pkt = 11'd64;
      fifo_lvl = 8'd100; fifo_thr = 8'd16; halt_st = 1'b0;
      repeat (3) tick();
      chk("R1 stat reset", stat_q, 5'h00);
      chk("R1 mask reset", mask_q, 5'h00);
      chk("R1 irq reset", irq, 1'b0);
      rst_n = 1'b1;
      tick(); tick();
      chk("R1 stat idle", stat_q, 5'h00);

      // table walk: R2 R3 R4
      for (int k = 0; k < NV; k++) begin
         idle();
         tx_done = VEC[k][13];
         tx_len  = VEC[k][12:2];
         tick();
         chk("R2 eop", stat_q[2], VEC[k][1]);
         chk("R3/R4 eot", stat_q[1], VEC[k][0]);
         clr_stat(5'b00110);
         chk("R8 cleared", stat_q, 5'h00);
      end

      // R4: bus reset forgets full history
      idle(); tx_done = 1'b1; tx_len = 11'd64; tick();
      idle(); bus_rst = 1'b1; tick();
      chk("R6 no unhalt without fall", stat_q[3], 1'b0);
      clr_stat(5'h1F);
      idle(); tx_done = 1'b1; tx_len = 11'd0; tick();
      chk("R4 zlp after bus reset", stat_q[1], 1'b0);
      clr_stat(5'h1F);

      // R5 halt with stall cause
      idle(); halt_st = 1'b1; stall_cause = 1'b1; tick(); idle();
      chk("R5 halt", stat_q, 5'b10000);
      chk("R10 irq masked off", irq, 1'b0);
      idle(); wr_en = 1'b1; wr_sel = 1'b1; wr_data = 5'b10000; tick(); idle();
      chk("R10 mask load", mask_q, 5'b10000);
      chk("R10 irq on", irq, 1'b1);
      clr_stat(5'b01111);
      chk("R8 write 0 keeps bit", stat_q[4], 1'b1);
      clr_stat(5'b10000);
      chk("R8 write 1 clears", stat_q[4], 1'b0);
      chk("R10 irq off after clear", irq, 1'b0);

      // R6 unhalt by SETUP
      idle(); halt_st = 1'b0; setup_rx = 1'b1; tick(); idle();
      chk("R6 unhalt setup", stat_q, 5'b01000);
      clr_stat(5'h1F);
      // R5 rise without cause
      idle(); halt_st = 1'b1; tick();
      chk("R5 no halt without stall", stat_q[4], 1'b0);
      // R6 fall without cause
      idle(); halt_st = 1'b0; tick();
      chk("R6 no unhalt without cause", stat_q[3], 1'b0);
      // R6 unhalt by bus reset
      idle(); halt_st = 1'b1; stall_cause = 1'b1; tick();
      idle(); halt_st = 1'b0; bus_rst = 1'b1; tick(); idle();
      chk("R6 unhalt bus reset", stat_q, 5'b11000);
      clr_stat(5'h1F);

      // R7 level crossing
      idle(); fifo_lvl = 8'd10; tick();
      chk("R7 crossing", stat_q[0], 1'b1);
      clr_stat(5'b00001);
      tick(); tick();
      chk("R7 no refire while low", stat_q[0], 1'b0);
      idle(); fifo_lvl = 8'd16; tick();
      chk("R7 at threshold no event", stat_q[0], 1'b0);

      // R9 set wins over clear
      idle(); fifo_lvl = 8'd15; tx_done = 1'b1; tx_len = 11'd64;
      wr_en = 1'b1; wr_sel = 1'b0; wr_data = 5'b00101; tick(); idle();
      chk("R9 set wins", stat_q, 5'b00101);
      idle(); wr_en = 1'b1; wr_sel = 1'b1; wr_data = 5'b00001; tick(); idle();
      chk("R10 irq on lvl", irq, 1'b1);

      summary();
   end
endmodule